// File: doc/BRIEF.md
# Predicate Define Compare Unit

This block carries out compare-to-predicate operations. Each operation compares two integer operands under a 3-bit compare code and can update two one-bit predicate registers. Each destination has its own update type, and that type sets whether the register is always written or written only on a hit. A qualifying predicate, read from the same register file, changes these rules. It does not simply cancel the operation.

The block holds a 16-entry file of one-bit predicates with two write ports. Entry 0 is hardwired true. Read ports let other pipeline stages look at any predicate without delay. Updates land at the next clock edge. When both destinations write the same entry in the same cycle, the first destination wins.

Top module: `pred_cmp_unit`

## Requirements
- R1: Compare codes on `op_i`: 0 equal, 1 not equal, 2 signed less-than, 3 signed less-or-equal, 4 unsigned less-than, 5 unsigned less-or-equal. Codes 6 and 7 give a false result.
- R2: With the qualifier at 1, a destination of type 0 (plain) takes the compare result. A destination of type 1 (plain-inverted) takes its inverse.
- R3: With the qualifier at 1, a destination of type 2 (accumulate) is set to 1 only when the result is true. A destination of type 3 (accumulate-inverted) is set to 1 only when the result is false. In every other case these destinations keep their value.
- R4: With the qualifier at 0, a type 0 or type 1 destination is cleared to 0, whatever the compare result.
- R5: With the qualifier at 0, a type 2 or type 3 destination keeps its value.
- R6: The qualifier is the predicate selected by `pin_idx_i`, taken as it stands before the clock edge that applies the operation.
- R7: Updates become visible on the read ports one clock edge after `valid_i` is sampled high. Read ports are combinational on the stored file.
- R8: Predicate 0 always reads 1, and writes to it are ignored.
- R9: When both destinations name the same entry and both write, destination 1 wins. When only one of them writes, that write takes effect.
- R10: With `valid_i` low, no predicate changes.
- R11: After reset, predicates 1 to 15 read 0 and predicate 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Compare code |
| src1_i | input | DATA_W | First operand |
| src2_i | input | DATA_W | Second operand |
| pin_idx_i | input | 4 | Index of qualifying predicate |
| dst1_idx_i | input | 4 | Destination 1 index |
| dst1_type_i | input | 2 | Destination 1 update type |
| dst2_idx_i | input | 4 | Destination 2 index |
| dst2_type_i | input | 2 | Destination 2 update type |
| rd_idx_i | input | NRD*4 | Packed read indices, port k at bits [4k+3:4k] |
| rd_data_o | output | NRD | Read data, bit k for port k |

## Verification
Assertions check four things on every cycle: cleared plain destinations when the qualifier is low, unchanged accumulate destinations in the same case, a frozen file when no operation is present, and entry 0 reading true. They also check that a port-1 write lands on the next edge. The bench's scenarios are needed for the rest. These are the signed and unsigned boundary operands of every compare code, accumulate chains across several operations, both same-index collision cases, and a qualifier that the same operation overwrites. These are compared against a behavioural model over a long random run.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;
  typedef enum logic [2:0] {
    CMP_EQ   = 3'd0,
    CMP_NE   = 3'd1,
    CMP_LT   = 3'd2,
    CMP_LE   = 3'd3,
    CMP_LTU  = 3'd4,
    CMP_LEU  = 3'd5,
    CMP_RSV6 = 3'd6,
    CMP_RSV7 = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    PT_UNC   = 2'd0,
    PT_UNC_N = 2'd1,
    PT_OR    = 2'd2,
    PT_OR_N  = 2'd3
  } ptype_e;

  typedef struct packed {
    logic en;
    logic val;
  } pwr_t;
endpackage

// File: rtl/pred_cmp_alu.sv
module pred_cmp_alu #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_o
);
  import pred_cmp_pkg::*;

  logic eq, lt_s, lt_u;
  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    case (cmp_op_e'(op_i))
      CMP_EQ:  res_o = eq;
      CMP_NE:  res_o = !eq;
      CMP_LT:  res_o = lt_s;
      CMP_LE:  res_o = lt_s | eq;
      CMP_LTU: res_o = lt_u;
      CMP_LEU: res_o = lt_u | eq;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_update_rule.sv
module pred_update_rule (
  input  logic                 valid_i,
  input  logic [1:0]           ptype_i,
  input  logic                 pin_i,
  input  logic                 res_i,
  output pred_cmp_pkg::pwr_t   wr_o
);
  import pred_cmp_pkg::*;

  always_comb begin
    wr_o = '0;
    case (ptype_e'(ptype_i))
      PT_UNC:   begin wr_o.en = 1'b1;            wr_o.val = pin_i & res_i;  end
      PT_UNC_N: begin wr_o.en = 1'b1;            wr_o.val = pin_i & ~res_i; end
      PT_OR:    begin wr_o.en = pin_i & res_i;   wr_o.val = 1'b1;           end
      PT_OR_N:  begin wr_o.en = pin_i & ~res_i;  wr_o.val = 1'b1;           end
      default:  wr_o = '0;
    endcase
    if (!valid_i) wr_o.en = 1'b0;
  end
endmodule

// File: rtl/pred_regfile.sv
module pred_regfile #(
  parameter int NPRED = 16,
  parameter int NWR   = 2,
  parameter int NRD   = 2,
  localparam int IDX_W = $clog2(NPRED)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NWR-1:0]         we_i,
  input  logic [NWR*IDX_W-1:0]   widx_i,
  input  logic [NWR-1:0]         wd_i,
  input  logic [NRD*IDX_W-1:0]   rd_idx_i,
  output logic [NRD-1:0]         rd_data_o,
  output logic [NPRED-1:0]       state_o
);
  logic [NPRED-1:0] q;

  assign q[0] = 1'b1;  // hardwired true

  for (genvar r = 1; r < NPRED; r++) begin : g_reg
    logic hit, nxt, bit_q;
    always_comb begin
      hit = 1'b0;
      nxt = bit_q;
      // lowest port number applied last, so it wins
      for (int p = NWR-1; p >= 0; p--) begin
        if (we_i[p] && widx_i[p*IDX_W +: IDX_W] == IDX_W'(r)) begin
          hit = 1'b1;
          nxt = wd_i[p];
        end
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  bit_q <= 1'b0;
      else if (hit) bit_q <= nxt;
    end
    assign q[r] = bit_q;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_data_o[k] = q[rd_idx_i[k*IDX_W +: IDX_W]];
  end

  assign state_o = q;

  assert_wr0_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && widx_i[IDX_W-1:0] != '0) |=> q[$past(widx_i[IDX_W-1:0])] == $past(wd_i[0]));
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
  parameter int DATA_W = 32,
  parameter int NPRED  = 16,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(NPRED),
  localparam int NDST  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [DATA_W-1:0]    src1_i,
  input  logic [DATA_W-1:0]    src2_i,
  input  logic [IDX_W-1:0]     pin_idx_i,
  input  logic [IDX_W-1:0]     dst1_idx_i,
  input  logic [1:0]           dst1_type_i,
  input  logic [IDX_W-1:0]     dst2_idx_i,
  input  logic [1:0]           dst2_type_i,
  input  logic [NRD*IDX_W-1:0] rd_idx_i,
  output logic [NRD-1:0]       rd_data_o
);
  import pred_cmp_pkg::*;

  logic                  res, pin;
  logic [NPRED-1:0]      state;
  logic [NDST*2-1:0]     types;
  logic [NDST*IDX_W-1:0] idxs;
  pwr_t [NDST-1:0]       wr;
  logic [NDST-1:0]       we, wd;

  assign types = {dst2_type_i, dst1_type_i};
  assign idxs  = {dst2_idx_i, dst1_idx_i};
  assign pin   = state[pin_idx_i];

  pred_cmp_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (op_i),
    .a_i  (src1_i),
    .b_i  (src2_i),
    .res_o(res)
  );

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    pred_update_rule u_rule (
      .valid_i(valid_i),
      .ptype_i(types[d*2 +: 2]),
      .pin_i  (pin),
      .res_i  (res),
      .wr_o   (wr[d])
    );
    assign we[d] = wr[d].en;
    assign wd[d] = wr[d].val;
  end

  pred_regfile #(.NPRED(NPRED), .NWR(NDST), .NRD(NRD)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .widx_i   (idxs),
    .wd_i     (wd),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_data_o),
    .state_o  (state)
  );

  assert_unc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pin && !dst1_type_i[1] && dst1_idx_i != '0)
    |=> state[$past(dst1_idx_i)] == 1'b0);

  assert_or_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pin && dst1_type_i[1] && dst1_idx_i != dst2_idx_i)
    |=> state[$past(dst1_idx_i)] == $past(state[dst1_idx_i]));

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state));

  assert_p0_true_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i[IDX_W-1:0] == '0) |-> rd_data_o[0]);
endmodule

// File: tb/sim_pred_cmp_unit.sv
`timescale 1ns/1ps
module sim_pred_cmp_unit;
  localparam int DW = 32;
  localparam int NP = 16;

  logic clk = 0, rst_n = 0;
  logic valid = 0;
  logic [2:0] op = 0;
  logic [DW-1:0] s1 = 0, s2 = 0;
  logic [3:0] pidx = 0, d1 = 0, d2 = 0;
  logic [1:0] t1 = 0, t2 = 0;
  logic [7:0] ridx = 0;
  logic [1:0] rdata;

  int total = 0, bad = 0;
  string tag = "R11";
  bit m [NP];

  always #5 clk = ~clk;

  pred_cmp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .src1_i(s1), .src2_i(s2), .pin_idx_i(pidx),
    .dst1_idx_i(d1), .dst1_type_i(t1), .dst2_idx_i(d2), .dst2_type_i(t2),
    .rd_idx_i(ridx), .rd_data_o(rdata)
  );

  function automatic bit cmp_ref(input logic [2:0] o, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (o)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) <  $signed(b);
      3'd3: return $signed(a) <= $signed(b);
      3'd4: return a <  b;
      3'd5: return a <= b;
      default: return 0;
    endcase
  endfunction

  // applies one destination rule to the model; returns whether it writes
  function automatic bit rule(input logic [1:0] t, input bit p, input bit r, output bit v);
    v = 1;
    case (t)
      2'd0: begin v = p & r;  return 1; end
      2'd1: begin v = p & !r; return 1; end
      2'd2: return p & r;
      default: return p & !r;
    endcase
  endfunction

  task automatic check_all();
    for (int k = 0; k < NP/2; k++) begin
      ridx = {4'(2*k+1), 4'(2*k)};
      #0.4;
      for (int j = 0; j < 2; j++) begin
        total++;
        if (rdata[j] !== m[2*k+j]) begin
          bad++;
          $display("FAIL %s p%0d got %0b exp %0b", tag, 2*k+j, rdata[j], m[2*k+j]);
        end
      end
    end
  endtask

  task automatic issue(input bit v, input logic [2:0] o, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [3:0] pi, input logic [3:0] i1, input logic [1:0] ty1,
                       input logic [3:0] i2, input logic [1:0] ty2);
    bit p, r, w1, w2, v1, v2;
    valid = v; op = o; s1 = a; s2 = b; pidx = pi; d1 = i1; t1 = ty1; d2 = i2; t2 = ty2;
    p = m[pi];
    r = cmp_ref(o, a, b);
    w1 = rule(ty1, p, r, v1);
    w2 = rule(ty2, p, r, v2);
    @(posedge clk);
    if (v) begin
      if (w2 && i2 != 0) m[i2] = v2;
      if (w1 && i1 != 0) m[i1] = v1;  // R9: destination 1 wins
    end
    @(negedge clk);
    valid = 0;
    check_all();
  endtask

  initial begin
    #(200000*10);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] av [4];
    logic [DW-1:0] bv [4];
    av = '{32'hFFFF_FFFF, 32'd1, 32'd3, 32'd0};
    bv = '{32'd1, 32'hFFFF_FFFF, 32'd3, 32'hFFFF_FFFF};
    for (int i = 0; i < NP; i++) m[i] = (i == 0);
    #22 rst_n = 1;
    @(negedge clk);
    tag = "R11"; check_all();

    tag = "R8";  issue(1, 3'd1, 5, 5, 0, 0, 2'd0, 0, 2'd1);   // writes to p0 ignored
    tag = "R2";  issue(1, 3'd0, 5, 5, 0, 1, 2'd0, 2, 2'd1);   // p1=1 p2=0
    tag = "R1";
    for (int o = 0; o < 8; o++)
      for (int q = 0; q < 4; q++)
        issue(1, 3'(o), av[q], bv[q], 0, 3, 2'd0, 4, 2'd1);
    tag = "R3";
    issue(1, 3'd0, 1, 2, 0, 5, 2'd2, 6, 2'd3);   // false: p5 held 0, p6 set
    issue(1, 3'd0, 2, 2, 0, 5, 2'd2, 6, 2'd3);   // true: p5 set, p6 held
    issue(1, 3'd0, 1, 2, 0, 5, 2'd2, 7, 2'd2);   // false: p5 stays 1
    tag = "R5";  issue(1, 3'd0, 2, 2, 2, 5, 2'd2, 6, 2'd3);   // qualifier p2=0
    issue(1, 3'd1, 2, 2, 2, 5, 2'd3, 6, 2'd2);
    tag = "R4";  issue(1, 3'd0, 2, 2, 2, 1, 2'd0, 7, 2'd1);   // p1 cleared
    tag = "R9";
    issue(1, 3'd0, 4, 4, 0, 8, 2'd0, 8, 2'd1);   // d1=1 beats d2=0
    issue(1, 3'd0, 4, 4, 0, 9, 2'd1, 9, 2'd0);   // d1=0 beats d2=1
    issue(1, 3'd0, 1, 4, 0, 8, 2'd2, 8, 2'd1);   // d1 no write, d2 writes 1
    tag = "R10"; issue(0, 3'd0, 4, 4, 0, 8, 2'd1, 5, 2'd1);
    tag = "R6";
    issue(1, 3'd0, 4, 4, 8, 8, 2'd1, 10, 2'd0);  // qualifier p8=1 read before overwrite
    issue(1, 3'd0, 4, 4, 8, 11, 2'd0, 8, 2'd2);  // p8 now 0: p11 cleared
    tag = "R7";
    for (int n = 0; n < 600; n++)
      issue($urandom_range(0, 7) != 0, 3'($urandom), ($urandom_range(0, 1) != 0) ? $urandom : 32'($urandom_range(0, 3)),
            ($urandom_range(0, 1) != 0) ? $urandom : 32'($urandom_range(0, 3)),
            4'($urandom), 4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule